// File: doc/BRIEF.md
# Tape Byte Transfer Buffer

This block is the programmed-I/O byte path of a magnetic tape controller. It keeps a single-byte data register between the host and the tape transport. It uses one busy flag as the handshake between the two sides. The meaning of busy depends on the direction. On a read, busy high says the register is empty and waits for the next tape byte. On a write, busy high says the register holds a host byte that the transport has not yet taken.

A command start chooses the direction and arms an internal pacer. The pacer fires once every `BYTE_GAP` clocks. On each pacer tick of a read, the block loads the next record byte from the transport, clears busy and raises an interrupt. It flags an overrun when the host did not collect the previous byte. On each pacer tick of a write, the block passes the held byte to the transport, clears busy and interrupts. The first tick that finds the register empty ends the record. A record that ends with no bytes causes no tape write. Record length is capped at `MAX_LEN` bytes in both directions.

Top module: `tape_byte_buffer`

## Requirements
- R1: After reset, busy is 1, error is 0 and irq is 0.
- R2: A command start with cmd_write=0 (read) sets busy to 1. With cmd_write=1 (write) it clears busy. Either start clears error.
- R3: A host_rd or host_wr pulse while a transfer is active sets busy on the next edge. While no transfer is active, a host strobe leaves busy unchanged.
- R4: During a read, the first pacer tick comes BYTE_GAP edges after the start edge, and further ticks follow at the same spacing. A tick that finds rd_avail=1 loads rd_byte into host_rdata, clears busy, pulses irq and pulses rd_take.
- R5: A read tick that loads a byte while busy is still 0 (the previous byte was not read) sets error.
- R6: A read ends on the first tick that finds rd_avail=0, or after MAX_LEN bytes have been loaded. That tick pulses xfer_end, gives no irq, and no rd_take follows it.
- R7: During a write, a tick with busy=1 pulses tape_wr_strobe with the held byte on tape_wr_data, clears busy and pulses irq.
- R8: During a write, a tick with busy=0 ends the record: it pulses xfer_end and pulses wr_commit, with wr_len equal to the number of bytes stored.
- R9: A write record that ends with zero bytes stored pulses xfer_end without wr_commit.
- R10: Write bytes after the first MAX_LEN are dropped: they still clear busy and raise irq, but give no tape_wr_strobe, and wr_len stays MAX_LEN.
- R11: A host_wr during an active write while wr_stopping=1 sets error (write overrun). The same strobe during a read does not.
- R12: Only bits [7:0] of host_wdata are stored in the data register.
- R13: Once set, error stays set until the next command start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a transfer, one-cycle pulse |
| cmd_write | input | 1 | Direction at start: 1 write, 0 read |
| wr_stopping | input | 1 | Write command is in its stopping phase |
| host_rd | input | 1 | Host read strobe of the data register |
| host_wr | input | 1 | Host write strobe of the data register |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | 8 | Data register contents |
| rd_avail | input | 1 | Transport has another record byte |
| rd_byte | input | 8 | Next record byte from the transport |
| rd_take | output | 1 | Pulse: transport byte consumed |
| tape_wr_strobe | output | 1 | Pulse: byte appended to the record |
| tape_wr_data | output | 8 | Byte being appended |
| wr_commit | output | 1 | Pulse: a non-empty write record is complete |
| wr_len | output | LEN_W | Bytes counted in the current record |
| xfer_end | output | 1 | Pulse: record ended |
| busy | output | 1 | Handshake flag |
| error | output | 1 | Sticky overrun flag |
| irq | output | 1 | Pulse: byte interrupt |

## Verification
The irq, rd_take, tape_wr_strobe, xfer_end and wr_commit pulses are registered. Each one appears exactly BYTE_GAP edges after the start edge and then on every following tick. Busy answers a host strobe one edge after the strobe, and the write-overrun error appears on that same edge. A read-overrun error appears on the tick edge itself. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start to the first pulse and compares the count with BYTE_GAP. Its scoreboard queue holds every byte the host writes and pops one entry for each tape strobe the monitor sees.

// File: rtl/bytebuf_pkg.sv
package bytebuf_pkg;

    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic irq;
        logic take;
        logic strobe;
        logic commit;
        logic done;
    } pulse_t;

    localparam pulse_t PULSE_NONE = '{irq: 1'b0, take: 1'b0, strobe: 1'b0,
                                      commit: 1'b0, done: 1'b0};

    function automatic xfer_mode_e mode_of(input logic is_write);
        return is_write ? MODE_WRITE : MODE_READ;
    endfunction

endpackage

// File: rtl/bytebuf_pacer.sv
module bytebuf_pacer #(
    parameter int GAP = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bytebuf_tally.sv
module bytebuf_tally #(
    parameter int MAX_LEN = 65536,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [LEN_W-1:0] count,
    output logic             full
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] cnt_q;

    assign count = cnt_q;
    assign full  = (cnt_q == CAP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (bump && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tape_byte_buffer.sv
module tape_byte_buffer
    import bytebuf_pkg::*;
#(
    parameter int BYTE_GAP = 10,
    parameter int MAX_LEN  = 65536,
    parameter int HOST_W   = 16,
    parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic              wr_stopping,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rd_avail,
    input  logic [7:0]        rd_byte,
    output logic              rd_take,
    output logic              tape_wr_strobe,
    output logic [7:0]        tape_wr_data,
    output logic              wr_commit,
    output logic [LEN_W-1:0]  wr_len,
    output logic              xfer_end,
    output logic              busy,
    output logic              error,
    output logic              irq
);
    xfer_mode_e       mode_q;
    logic             active_q;
    logic             busy_q;
    logic             error_q;
    logic [7:0]       data_q;
    logic [7:0]       wdata_q;
    pulse_t           pulse_q;
    logic             tick;
    logic             cap_full;
    logic [LEN_W-1:0] stored;
    logic             accept;
    logic             rd_load;
    logic             wr_push;

    bytebuf_pacer #(.GAP(BYTE_GAP)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd_start),
        .run     (active_q && !cmd_start),
        .tick    (tick)
    );

    // A read byte is loaded only while the record continues and room is left
    assign rd_load = tick && (mode_q == MODE_READ) && rd_avail && !cap_full;
    // A write byte is taken whenever the register is full
    assign wr_push = tick && (mode_q == MODE_WRITE) && busy_q;
    assign accept  = !cmd_start && (rd_load || wr_push);

    bytebuf_tally #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd_start),
        .bump  (accept),
        .count (stored),
        .full  (cap_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_READ;
            active_q <= 1'b0;
            busy_q   <= 1'b1;
            error_q  <= 1'b0;
            data_q   <= '0;
            wdata_q  <= '0;
            pulse_q  <= PULSE_NONE;
        end else begin
            pulse_q <= PULSE_NONE;
            if (host_wr) begin
                data_q <= host_wdata[7:0];
            end
            if (cmd_start) begin
                mode_q   <= mode_of(cmd_write);
                active_q <= 1'b1;
                busy_q   <= !cmd_write;
                error_q  <= 1'b0;
            end else begin
                if (tick) begin
                    if (mode_q == MODE_READ) begin
                        if (rd_load) begin
                            data_q       <= rd_byte;
                            busy_q       <= 1'b0;
                            pulse_q.irq  <= 1'b1;
                            pulse_q.take <= 1'b1;
                            if (!busy_q) begin
                                error_q <= 1'b1;
                            end
                        end else begin
                            active_q     <= 1'b0;
                            pulse_q.done <= 1'b1;
                        end
                    end else begin
                        if (busy_q) begin
                            if (!cap_full) begin
                                pulse_q.strobe <= 1'b1;
                                wdata_q        <= data_q;
                            end
                            busy_q      <= 1'b0;
                            pulse_q.irq <= 1'b1;
                        end else begin
                            active_q       <= 1'b0;
                            pulse_q.done   <= 1'b1;
                            pulse_q.commit <= (stored != '0);
                        end
                    end
                end
                if (active_q && (host_rd || host_wr)) begin
                    busy_q <= 1'b1;
                end
                if (active_q && host_wr && wr_stopping && (mode_q == MODE_WRITE)) begin
                    error_q <= 1'b1;
                end
            end
        end
    end

    assign host_rdata     = data_q;
    assign rd_take        = pulse_q.take;
    assign tape_wr_strobe = pulse_q.strobe;
    assign tape_wr_data   = wdata_q;
    assign wr_commit      = pulse_q.commit;
    assign wr_len         = stored;
    assign xfer_end       = pulse_q.done;
    assign busy           = busy_q;
    assign error          = error_q;
    assign irq            = pulse_q.irq;
endmodule

// File: rtl/bytebuf_chk.sv
module bytebuf_chk #(
    parameter int MAX_LEN = 65536,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_start,
    input logic             host_rd,
    input logic             host_wr,
    input logic             active_q,
    input logic             rd_avail,
    input logic             rd_take,
    input logic             wr_commit,
    input logic             xfer_end,
    input logic [LEN_W-1:0] wr_len,
    input logic             busy,
    input logic             error,
    input logic             irq
);
    // R3
    host_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !cmd_start && (host_rd || host_wr)) |=> busy);

    // R2
    start_clears_error_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (!error && !irq));

    // R4
    irq_leaves_busy_low_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy || $past(host_rd || host_wr)));

    // R6
    take_needs_avail_chk: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> $past(rd_avail));

    // R9
    commit_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (xfer_end && (wr_len != '0)));

    // R10
    len_capped_chk: assert property (@(posedge clk) disable iff (rst)
        wr_len <= LEN_W'(MAX_LEN));

    // R13
    error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (error && !cmd_start) |=> error);
endmodule

bind tape_byte_buffer bytebuf_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .active_q  (active_q),
    .rd_avail  (rd_avail),
    .rd_take   (rd_take),
    .wr_commit (wr_commit),
    .xfer_end  (xfer_end),
    .wr_len    (wr_len),
    .busy      (busy),
    .error     (error),
    .irq       (irq)
);

// File: tb/tape_byte_buffer_tb.sv
module tape_byte_buffer_tb;
    localparam int GAP   = 10;
    localparam int MAXL  = 6;
    localparam int HW    = 16;
    localparam int LW    = $clog2(MAXL + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic          wr_stopping = 1'b0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [HW-1:0] host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          rd_avail;
    logic [7:0]    rd_byte;
    logic          rd_take;
    logic          tape_wr_strobe;
    logic [7:0]    tape_wr_data;
    logic          wr_commit;
    logic [LW-1:0] wr_len;
    logic          xfer_end;
    logic          busy;
    logic          error;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] rec [0:7];
    int rec_len  = 0;
    int takes    = 0;
    int take_base = 0;
    int idx;
    int strobes  = 0;
    logic [7:0] exp_q [$];
    int pushed   = 0;

    assign idx      = takes - take_base;
    assign rd_avail = (idx < rec_len);
    assign rd_byte  = rec[idx[2:0]];

    always #5 clk = ~clk;

    tape_byte_buffer #(.BYTE_GAP(GAP), .MAX_LEN(MAXL), .HOST_W(HW)) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .wr_stopping(wr_stopping), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rd_avail(rd_avail),
        .rd_byte(rd_byte), .rd_take(rd_take), .tape_wr_strobe(tape_wr_strobe),
        .tape_wr_data(tape_wr_data), .wr_commit(wr_commit), .wr_len(wr_len),
        .xfer_end(xfer_end), .busy(busy), .error(error), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: transport side of the scoreboard
    always @(negedge clk) begin
        cycles++;
        if (rd_take) takes++;
        if (tape_wr_strobe) begin
            strobes++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 actual=%0h expected=none", tape_wr_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (tape_wr_data !== e) begin
                    errors++;
                    $display("FAIL R7/R12 actual=%0h expected=%0h", tape_wr_data, e);
                end
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic start(input logic wr);
        cmd_write = wr;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic hrd();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Driver: host side of the scoreboard
    task automatic hwr(input logic [HW-1:0] d);
        host_wdata = d;
        host_wr = 1'b1;
        if (pushed < MAXL) exp_q.push_back(d[7:0]);
        pushed++;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_evt(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(irq || xfer_end) && n < 200);
    endtask

    task automatic load_rec(input int n);
        for (int i = 0; i < 8; i++) rec[i] = 8'(8'h31 + 8'(i * 17));
        rec_len = n;
        take_base = takes;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1 && error == 0 && irq == 0, "R1 reset", {busy, error, irq}, 3'b100);

        // Read, host keeps up
        load_rec(3);
        start(1'b0);
        check(busy == 1 && error == 0, "R2 read start", {busy, error}, 2'b10);
        for (int b = 0; b < 3; b++) begin
            wait_evt(n);
            if (b == 0) check(n == GAP, "R4 first tick spacing", n, GAP);
            check(irq && rd_take && !busy && host_rdata == rec[b], "R4 byte load",
                  host_rdata, rec[b]);
            hrd();
            check(busy == 1, "R3 host read sets busy", busy, 1);
        end
        wait_evt(n);
        check(xfer_end && !irq && error == 0, "R6 record end", {xfer_end, irq, error}, 3'b100);
        check(takes - take_base == 3, "R6 take count", takes - take_base, 3);

        // Read overrun
        load_rec(2);
        start(1'b0);
        wait_evt(n);
        check(error == 0, "R5 first byte no error", error, 0);
        wait_evt(n);
        check(irq && error == 1, "R5 read overrun", error, 1);
        wait_evt(n);
        check(xfer_end && error == 1, "R13 error sticky", error, 1);
        repeat (3) @(negedge clk);
        check(error == 1, "R13 error held idle", error, 1);

        // Read capped at maximum
        load_rec(8);
        start(1'b0);
        check(error == 0, "R2 start clears error", error, 0);
        do begin
            wait_evt(n);
            if (irq) hrd();
        end while (!xfer_end && n < 200);
        check(takes - take_base == MAXL, "R6 max length read", takes - take_base, MAXL);

        // Write three bytes
        start(1'b1);
        check(busy == 0 && error == 0, "R2 write start", {busy, error}, 2'b00);
        pushed = 0; strobes = 0;
        hwr(16'h12A5);
        check(busy == 1, "R3 host write sets busy", busy, 1);
        wait_evt(n);
        check(irq && tape_wr_strobe && !busy, "R7 byte taken", {irq, tape_wr_strobe, busy}, 3'b110);
        hwr(16'hFF3C);
        wait_evt(n);
        hwr(16'h0007);
        wait_evt(n);
        wait_evt(n);
        check(xfer_end && wr_commit && wr_len == 3, "R8 commit length", wr_len, 3);
        check(strobes == 3 && exp_q.size() == 0, "R12 scoreboard drained", strobes, 3);

        // Empty write record, then idle host strobe
        start(1'b1);
        wait_evt(n);
        check(xfer_end && !wr_commit, "R9 empty record", {xfer_end, wr_commit}, 2'b10);
        hrd();
        check(busy == 0, "R3 idle strobe ignored", busy, 0);

        // Write beyond maximum
        start(1'b1);
        pushed = 0; strobes = 0;
        for (int b = 0; b < 8; b++) begin
            hwr(16'h0040 + 16'(b));
            wait_evt(n);
            check(irq, "R10 irq on each byte", irq, 1);
        end
        wait_evt(n);
        check(xfer_end && wr_commit && wr_len == MAXL, "R10 capped length", wr_len, MAXL);
        check(strobes == MAXL, "R10 dropped bytes", strobes, MAXL);

        // Host write during stopping phase
        load_rec(0);
        start(1'b0);
        wr_stopping = 1'b1;
        hwr(16'h0011);
        exp_q.delete();
        check(error == 0, "R11 read mode no overrun", error, 0);
        wait_evt(n);
        start(1'b1);
        pushed = 0;
        hwr(16'h0022);
        check(error == 1, "R11 write overrun", error, 1);
        wr_stopping = 1'b0;
        wait_evt(n);
        wait_evt(n);
        check(xfer_end && error == 1, "R13 error kept to end", error, 1);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule